// File: doc/BRIEF.md
# Carry-Chain Arithmetic Slice Array

This block is a chain of N arithmetic half-cells joined by a ripple carry. Each bit position has two 4-input lookup functions. The functions share three select inputs and each has its own fourth input. The cell inverts the value chosen for its second adder input, then adds it to the first function's output and the incoming carry. The result is one sum bit and a carry that passes to the next bit. Truth tables are parameters set per bit, so one structure can act as an adder, a subtractor, a gated adder, or any other bitwise pair of functions feeding a carry chain.

A static mode parameter selects one of two ways of wiring the second adder input. In plain mode, each bit adds its own second function. In shared mode, each bit's second function feeds the adder of the bit above it. This allows a carry-save step and the ripple to sit on the same chain, so three operand bits enter at each position. Bit 0 takes its forwarded value from an external port. The value forwarded out of the top bit is brought out on its own pin.

Operands enter through a valid/ready stream, and the result leaves through one. One result register sits between them. The input may accept a new operand set when the register is empty, or when the register is being drained in the same cycle. A result is held unchanged for as long as the consumer holds ready low.

Top module: `arith_slice_chain`

## Requirements
- R1: For bit i, the first function is bit {d0[i],c[i],b[i],a[i]} of that bit's first 16-bit table, and the second function is bit {d1[i],c[i],b[i],a[i]} of its second table. The select input a is the least significant index bit.
- R2: In plain mode, bit i produces {carry into bit i+1, sum[i]} = first function + NOT second function + carry into bit i. The carry into bit 0 is the carry_in port.
- R3: carry_out is the carry leaving bit N-1.
- R4: In shared mode, the inverted adder input of bit i is the raw second function of bit i-1. For bit 0 it is the shared_in port, and shared_out is the raw second function of bit N-1.
- R5: In plain mode, shared_in has no effect on any output, and shared_out reads 0.
- R6: in_ready is high exactly when no result is held or out_ready is high. An operand set is taken when in_valid and in_ready are both high, and its result appears with out_valid one clock later.
- R7: While out_valid is high and out_ready is low, sum, carry_out and shared_out do not change.
- R8: While rst_n is low, out_valid is 0.
- R9: With first table 16'hAAAA and second table 16'hCCCC, and carry_in = 1, {carry_out,sum} = a + (2^N-1-b) + 1, which is a - b. carry_out = 1 means no borrow.
- R10: In shared mode, first table 16'h9696 (three-input XOR) and second table 16'h1717 (inverted majority) give sum + 2^N*(carry_out + NOT shared_out) = a + b + c + carry_in + NOT shared_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Block can take an operand set |
| op_a | input | N | Shared select input A per bit |
| op_b | input | N | Shared select input B per bit |
| op_c | input | N | Shared select input C per bit |
| op_d0 | input | N | Fourth input of the first function per bit |
| op_d1 | input | N | Fourth input of the second function per bit |
| carry_in | input | 1 | Carry into bit 0 |
| shared_in | input | 1 | Forwarded value into bit 0 (shared mode) |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| sum | output | N | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |
| shared_out | output | 1 | Forwarded value out of the top bit (shared mode), else 0 |

## Verification
The hardest case to reach from the ports combines two things. A carry enters at bit 0 and ripples through every position. In shared mode, the forwarded majority values also reach the top of the chain, while the consumer is stalling. Directed all-ones and all-zeros operand sets with both carry_in values start the run. After them, random valid and ready patterns create stalls that land on those long-ripple results. Three configurations share the same stimulus: a gated adder, a subtractor and a three-operand adder. The shared_in toggling that the plain-mode chains must ignore is therefore applied in the same cycles that exercise the shared-mode chain.

// File: rtl/arith_chain_pkg.sv
package arith_chain_pkg;
  typedef enum logic {
    CHAIN_PLAIN  = 1'b0,
    CHAIN_SHARED = 1'b1
  } chain_mode_e;

  localparam int TABLE_BITS = 16;
  localparam int SELECT_BITS = 4;
endpackage

// File: rtl/arith_lut4.sv
module arith_lut4 #(
  parameter logic [15:0] TABLE = 16'h0000
) (
  input  logic [3:0] sel,
  output logic       q
);
  // index order is {fourth, c, b, a}
  assign q = TABLE[sel];
endmodule

// File: rtl/arith_half_cell.sv
module arith_half_cell #(
  parameter logic [15:0] TABLE_F0 = 16'hAAAA,
  parameter logic [15:0] TABLE_F1 = 16'hCCCC
) (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d0,
  input  logic d1,
  input  logic addend_raw,
  input  logic cy_in,
  output logic f1_raw,
  output logic sum_bit,
  output logic cy_out
);
  logic f0_val;
  logic [1:0] total;

  arith_lut4 #(.TABLE(TABLE_F0)) u_f0 (.sel({d0, c, b, a}), .q(f0_val));
  arith_lut4 #(.TABLE(TABLE_F1)) u_f1 (.sel({d1, c, b, a}), .q(f1_raw));

  // the second adder input always enters inverted
  assign total   = {1'b0, f0_val} + {1'b0, ~addend_raw} + {1'b0, cy_in};
  assign sum_bit = total[0];
  assign cy_out  = total[1];
endmodule

// File: rtl/arith_chain_core.sv
module arith_chain_core
  import arith_chain_pkg::*;
#(
  parameter int          N    = 8,
  parameter chain_mode_e MODE = CHAIN_PLAIN,
  parameter logic [N*TABLE_BITS-1:0] TABLES_F0 = {N{16'hAAAA}},
  parameter logic [N*TABLE_BITS-1:0] TABLES_F1 = {N{16'hCCCC}}
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] c,
  input  logic [N-1:0] d0,
  input  logic [N-1:0] d1,
  input  logic         cy_in,
  input  logic         fwd_in,
  output logic [N-1:0] sum,
  output logic         cy_out,
  output logic         fwd_out
);
  logic [N:0]   carry;
  logic [N-1:0] f1_all;
  logic [N-1:0] addend;

  assign carry[0] = cy_in;

  for (genvar i = 0; i < N; i++) begin : g_bit
    arith_half_cell #(
      .TABLE_F0(TABLES_F0[i*TABLE_BITS +: TABLE_BITS]),
      .TABLE_F1(TABLES_F1[i*TABLE_BITS +: TABLE_BITS])
    ) u_cell (
      .a(a[i]), .b(b[i]), .c(c[i]), .d0(d0[i]), .d1(d1[i]),
      .addend_raw(addend[i]),
      .cy_in(carry[i]),
      .f1_raw(f1_all[i]),
      .sum_bit(sum[i]),
      .cy_out(carry[i+1])
    );

    if (MODE == CHAIN_SHARED) begin : g_shared
      if (i == 0) begin : g_base
        assign addend[i] = fwd_in;
      end else begin : g_link
        assign addend[i] = f1_all[i-1];
      end
    end else begin : g_plain
      assign addend[i] = f1_all[i];
    end
  end

  if (MODE == CHAIN_SHARED) begin : g_fwd_out
    assign fwd_out = f1_all[N-1];
  end else begin : g_fwd_none
    logic unused_fwd;
    assign unused_fwd = fwd_in;
    assign fwd_out    = 1'b0;
  end

  assign cy_out = carry[N];
endmodule

// File: rtl/arith_out_stage.sv
module arith_out_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         held_vld;
  logic [W-1:0] held_data;

  assign in_ready  = !held_vld || out_ready;
  assign out_valid = held_vld;
  assign out_data  = held_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld  <= 1'b0;
      held_data <= '0;
    end else if (in_ready) begin
      held_vld <= in_valid;
      if (in_valid) held_data <= in_data;
    end
  end
endmodule

// File: rtl/arith_slice_chain.sv
module arith_slice_chain
  import arith_chain_pkg::*;
#(
  parameter int          N    = 8,
  parameter chain_mode_e MODE = CHAIN_PLAIN,
  parameter logic [N*TABLE_BITS-1:0] TABLES_F0 = {N{16'hAAAA}},
  parameter logic [N*TABLE_BITS-1:0] TABLES_F1 = {N{16'hCCCC}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [N-1:0] op_c,
  input  logic [N-1:0] op_d0,
  input  logic [N-1:0] op_d1,
  input  logic         carry_in,
  input  logic         shared_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] sum,
  output logic         carry_out,
  output logic         shared_out
);
  localparam int RES_W = N + 2;

  logic [N-1:0]     comb_sum;
  logic             comb_cy;
  logic             comb_fwd;
  logic [RES_W-1:0] res_q;

  arith_chain_core #(
    .N(N), .MODE(MODE), .TABLES_F0(TABLES_F0), .TABLES_F1(TABLES_F1)
  ) u_core (
    .a(op_a), .b(op_b), .c(op_c), .d0(op_d0), .d1(op_d1),
    .cy_in(carry_in), .fwd_in(shared_in),
    .sum(comb_sum), .cy_out(comb_cy), .fwd_out(comb_fwd)
  );

  arith_out_stage #(.W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data({comb_fwd, comb_cy, comb_sum}),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(res_q)
  );

  assign sum        = res_q[N-1:0];
  assign carry_out  = res_q[N];
  assign shared_out = res_q[N+1];
endmodule

// File: rtl/arith_slice_chain_chk.sv
module arith_slice_chain_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] sum,
  input logic         carry_out,
  input logic         shared_out,
  input logic         mode_shared
);
  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  a_r6_accept_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r6_stall_only_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(sum) && $stable(carry_out)
                                && $stable(shared_out));

  a_r5_plain_fwd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_shared && out_valid |-> !shared_out);
endmodule

bind arith_slice_chain arith_slice_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .sum(sum), .carry_out(carry_out), .shared_out(shared_out),
  .mode_shared(MODE == arith_chain_pkg::CHAIN_SHARED)
);

// File: tb/arith_slice_chain_bench.sv
module arith_slice_chain_bench;
  localparam int N = 8;
  localparam int MASK = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [N-1:0] a = '0, b = '0, c = '0, d0 = '0, d1 = '0;
  logic cin = 1'b0, shin = 1'b0;

  logic rdy1, vld1, cy1, sh1; logic [N-1:0] s1;
  logic rdy2, vld2, cy2, sh2; logic [N-1:0] s2;
  logic rdy3, vld3, cy3, sh3; logic [N-1:0] s3;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // gated adder: f0 = a & ~d0, f1 = ~(b & ~d1)
  arith_slice_chain #(.N(N), .MODE(arith_chain_pkg::CHAIN_PLAIN),
    .TABLES_F0({N{16'h00AA}}), .TABLES_F1({N{16'hFF33}})) u_arith_slice_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .op_a(a), .op_b(b), .op_c(c), .op_d0(d0), .op_d1(d1),
    .carry_in(cin), .shared_in(shin), .out_valid(vld1), .out_ready(out_ready),
    .sum(s1), .carry_out(cy1), .shared_out(sh1));

  // subtractor: f0 = a, f1 = b
  arith_slice_chain #(.N(N), .MODE(arith_chain_pkg::CHAIN_PLAIN),
    .TABLES_F0({N{16'hAAAA}}), .TABLES_F1({N{16'hCCCC}})) u_sub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy2),
    .op_a(a), .op_b(b), .op_c(c), .op_d0(d0), .op_d1(d1),
    .carry_in(cin), .shared_in(shin), .out_valid(vld2), .out_ready(out_ready),
    .sum(s2), .carry_out(cy2), .shared_out(sh2));

  // three-operand: f0 = xor3, f1 = ~majority, shared mode
  arith_slice_chain #(.N(N), .MODE(arith_chain_pkg::CHAIN_SHARED),
    .TABLES_F0({N{16'h9696}}), .TABLES_F1({N{16'h1717}})) u_add3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy3),
    .op_a(a), .op_b(b), .op_c(c), .op_d0(d0), .op_d1(d1),
    .carry_in(cin), .shared_in(shin), .out_valid(vld3), .out_ready(out_ready),
    .sum(s3), .carry_out(cy3), .shared_out(sh3));

  // behavioural model state (value after the coming clock edge)
  bit m_vld = 0;
  int e1 = 0, e2 = 0, e3 = 0;
  bit e3_sh = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int tot3;
    chk(rdy1 == (!m_vld || out_ready), "R6 in_ready", rdy1, !m_vld || out_ready);
    chk(vld1 == m_vld && vld2 == m_vld && vld3 == m_vld, "R6 out_valid",
        {vld1, vld2, vld3}, {3{m_vld}});
    if (m_vld) begin
      // R1 R2: gated adder sum, held stable under stall (R7)
      chk({cy1, s1} == e1[N:0], "R1/R2 gated sum", {cy1, s1}, e1[N:0]);
      chk(cy1 == e1[N], "R3 carry_out", cy1, e1[N]);
      chk(sh1 == 1'b0 && sh2 == 1'b0, "R5 plain shared_out", {sh1, sh2}, 0);
      chk({cy2, s2} == e2[N:0], "R9 subtract", {cy2, s2}, e2[N:0]);
      tot3 = int'(s3) + ((int'(cy3) + int'(!sh3)) << N);
      chk(tot3 == e3, "R10 three-operand total", tot3, e3);
      chk(sh3 == e3_sh, "R4 shared_out", sh3, e3_sh);
    end
  endtask

  function automatic bit maj(input bit x, input bit y, input bit z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) begin
      @(negedge clk);
      chk(vld1 == 0 && vld2 == 0 && vld3 == 0, "R8 reset idle", {vld1, vld2, vld3}, 0);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      compare_all();
      // drive next operands and handshake
      if (k < 4) begin
        in_valid = 1'b1; out_ready = 1'b1; d0 = '0; d1 = '0;
        case (k)
          0: begin a = '1; b = 8'h01; c = '0; cin = 1'b0; shin = 1'b1; end
          1: begin a = '1; b = '1; c = '1; cin = 1'b1; shin = 1'b0; end
          2: begin a = '0; b = '0; c = '0; cin = 1'b0; shin = 1'b1; end
          default: begin a = 8'h05; b = 8'h07; c = 8'hFF; cin = 1'b1; shin = 1'b0; end
        endcase
      end else begin
        in_valid = ($urandom % 4) != 0;
        out_ready = ($urandom % 3) != 0;
        a = N'($urandom); b = N'($urandom); c = N'($urandom);
        d0 = ($urandom % 2) ? N'($urandom) : '0;
        d1 = ($urandom % 2) ? N'($urandom) : '0;
        cin = 1'($urandom); shin = 1'($urandom);
      end
      // model the coming edge
      if (!m_vld || out_ready) begin
        m_vld = in_valid;
        if (in_valid) begin
          e1 = (int'(a) & ~int'(d0) & MASK) + (int'(b) & ~int'(d1) & MASK) + int'(cin);
          e2 = int'(a) + ((~int'(b)) & MASK) + int'(cin);
          e3 = int'(a) + int'(b) + int'(c) + int'(cin) + int'(!shin);
          e3_sh = !maj(a[N-1], b[N-1], c[N-1]);
        end
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule